// File: doc/BRIEF.md
# USB Endpoint Buffer Descriptor Engine

This block sits between the serial engine of a full-speed USB device and a shared 16-bit packet memory. The packet memory holds a descriptor table of four 16-bit fields per endpoint. The serial engine gives an endpoint number and a direction. The engine then fetches the matching descriptor fields from the memory.

For an IN transaction the engine reads the transmit buffer address and the transmit byte count and returns them to the serial engine. For an OUT transaction it reads the receive buffer address and the receive descriptor word, and decodes the buffer capacity from that word. It then writes each received byte into the buffer, one byte lane at a time, and stops writing when the capacity is exceeded. A clean packet ends with the received byte count written back into the descriptor.

The table base and the access scheme are sampled when a request is accepted. In the normal scheme the 16-bit words are packed. In the padded scheme every data word is followed by an unused word, so every offset doubles. The memory returns read data in the cycle after a read request. Data bytes are taken only once the descriptor fetch is complete, three cycles after the request is accepted.

Top module: `usb_bd_engine`

## Requirements
- R1: In the normal scheme, field k of endpoint n is read at (base with bits 2:0 cleared) + 8n + 2k. The field numbers are: 0 transmit address, 1 transmit count, 2 receive address, 3 receive descriptor. Every memory address has bit 0 at zero.
- R2: In the padded scheme (pad_mode_i=1), field k of endpoint n is at cleared base + 16n + 4k. Buffer byte address a maps to memory word address (a>>1)*4.
- R3: An IN request reads field 0 and then field 1. With the done_o pulse it reports tx_addr_o as field 0 and tx_cnt_o as bits 9:0 of field 1 (bits 15:10 are ignored), with ack_o=1.
- R4: The receive descriptor word has the block-size flag in bit 15, the block count in bits 14:10 and the count in bits 9:0. With the flag at 0 the capacity is 2 × count, and a count of 0 gives capacity 0. With the flag at 1 the capacity is 32 × (count+1), capped at 1023.
- R5: OUT byte i is written to buffer address a+i. The lane is bit 0 of that address: 0 selects the low byte (mem_be_o=01) and 1 selects the high byte (10). In the normal scheme odd buffer addresses are allowed.
- R6: Bytes beyond the capacity are not written. The packet then ends with ovf_err_o=1 and ack_o=0, and the descriptor word is left untouched.
- R7: The count writeback is a full-word write (be=11) of the receive descriptor. It keeps bits 15:10 and puts the number of bytes received in bits 9:0. It happens only after the last byte and after every data write. A zero-length packet (rx_last_i with rx_valid_i low) writes a count of 0.
- R8: In the padded scheme a buffer address with bit 0 set gives align_err_o=1 and ack_o=0. In that case no data and no count are written.
- R9: done_o is a one-cycle pulse. ack_o, ovf_err_o and align_err_o hold until the next request is accepted. req_ready_o is high only when the engine is idle, and there is no memory access while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_base_i | input | AW | Descriptor table base byte address |
| pad_mode_i | input | 1 | 1 selects the padded access scheme |
| req_valid_i | input | 1 | Transaction request |
| req_ep_i | input | EP_W | Endpoint number |
| req_in_i | input | 1 | 1 = IN, 0 = OUT |
| req_ready_o | output | 1 | Engine idle, request accepted |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_last_i | input | 1 | End of OUT packet |
| mem_req_o | output | 1 | Memory access |
| mem_we_o | output | 1 | Write access |
| mem_addr_o | output | AW | Memory byte address of the 16-bit word |
| mem_be_o | output | 2 | Byte lane enables |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after request |
| done_o | output | 1 | Transaction finished |
| ack_o | output | 1 | Transaction accepted without error |
| ovf_err_o | output | 1 | OUT packet exceeded capacity |
| align_err_o | output | 1 | Odd buffer address in padded scheme |
| tx_addr_o | output | AW | Transmit buffer address |
| tx_cnt_o | output | CW | Transmit byte count |

## Verification
Two things can happen in the same cycle. The buffered write of one byte goes out on the memory port while the next byte is being taken in. The capacity limit can also be crossed by the very byte that carries rx_last_i. Both are provoked with back-to-back byte streams that end exactly at the capacity and one byte past it, at 32 and 1023 bytes. The bench holds a queue of every expected memory access, computed from the descriptor contents. It compares each access on the port against that queue on every clock. Any write after an overflow, or a count write placed before a data write, shows up as a mismatch or as an unexpected access.

// File: rtl/usb_bd_pkg.sv
`timescale 1ns/1ps
package usb_bd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_RD2, ST_WT, ST_RX, ST_LAST, ST_WB
  } bd_state_e;

  localparam logic [1:0] FLD_TXA = 2'd0;
  localparam logic [1:0] FLD_TXC = 2'd1;
  localparam logic [1:0] FLD_RXA = 2'd2;
  localparam logic [1:0] FLD_RXC = 2'd3;
endpackage

// File: rtl/bd_addr_gen.sv
`timescale 1ns/1ps
module bd_addr_gen #(
  parameter int unsigned EP_W = 3,
  parameter int unsigned AW   = 16
) (
  input  logic [AW-1:0]   base_i,
  input  logic [EP_W-1:0] ep_i,
  input  logic [1:0]      fld_i,
  input  logic            pad_i,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0] base_al;
  logic [AW-1:0] ep_ext, fld_ext;

  assign base_al = base_i & ~AW'(7);
  assign ep_ext  = AW'(ep_i);
  assign fld_ext = AW'(fld_i);

  always_comb begin
    if (pad_i) addr_o = base_al + (ep_ext << 4) + (fld_ext << 2);
    else       addr_o = base_al + (ep_ext << 3) + (fld_ext << 1);
  end
endmodule

// File: rtl/bd_cap_decode.sv
`timescale 1ns/1ps
module bd_cap_decode #(
  parameter int unsigned CW = 10
) (
  input  logic          big_i,
  input  logic [4:0]    num_i,
  output logic [CW-1:0] cap_o
);
  localparam int unsigned CAP_MAX = (1 << CW) - 1;
  logic [11:0] big;

  assign big = {2'b00, num_i, 5'b00000} + 12'd32;

  always_comb begin
    if (big_i) begin
      if (big > 12'(CAP_MAX)) cap_o = CW'(CAP_MAX);
      else                    cap_o = CW'(big);
    end else begin
      cap_o = CW'({num_i, 1'b0});
    end
  end
endmodule

// File: rtl/bd_byte_map.sv
`timescale 1ns/1ps
module bd_byte_map #(
  parameter int unsigned AW = 16
) (
  input  logic          pad_i,
  input  logic [AW-1:0] byte_addr_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    be_o
);
  always_comb begin
    if (pad_i) mem_addr_o = {byte_addr_i[AW-2:1], 2'b00};
    else       mem_addr_o = {byte_addr_i[AW-1:1], 1'b0};
    be_o = byte_addr_i[0] ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/usb_bd_engine.sv
`timescale 1ns/1ps
module usb_bd_engine
  import usb_bd_pkg::*;
#(
  parameter int unsigned EP_W = 3,
  parameter int unsigned AW   = 16,
  parameter int unsigned CW   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   tbl_base_i,
  input  logic            pad_mode_i,
  input  logic            req_valid_i,
  input  logic [EP_W-1:0] req_ep_i,
  input  logic            req_in_i,
  output logic            req_ready_o,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_last_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [1:0]      mem_be_o,
  output logic [15:0]     mem_wdata_o,
  input  logic [15:0]     mem_rdata_i,
  output logic            done_o,
  output logic            ack_o,
  output logic            ovf_err_o,
  output logic            align_err_o,
  output logic [AW-1:0]   tx_addr_o,
  output logic [CW-1:0]   tx_cnt_o
);
  bd_state_e       state_q;
  logic [EP_W-1:0] ep_q;
  logic            in_q, pad_q;
  logic [AW-1:0]   base_q, buf_q;
  logic [15:0]     rxd_q;
  logic [CW-1:0]   cnt_q;
  logic            ovf_q, aln_q, ack_q, done_q;
  logic [AW-1:0]   txa_q;
  logic [CW-1:0]   txc_q;
  logic            wr_q;
  logic [AW-1:0]   wa_q;
  logic [1:0]      wbe_q;
  logic [15:0]     wd_q;

  logic [1:0]      fld;
  logic [AW-1:0]   fld_addr, byte_addr, byte_mem_addr;
  logic [1:0]      byte_be;
  logic [CW-1:0]   cap;
  logic            rd;

  always_comb begin
    if (state_q == ST_RD1) fld = in_q ? FLD_TXA : FLD_RXA;
    else                   fld = in_q ? FLD_TXC : FLD_RXC;
  end

  assign byte_addr = buf_q + AW'(cnt_q);

  bd_addr_gen #(.EP_W(EP_W), .AW(AW)) u_agen (
    .base_i (base_q),
    .ep_i   (ep_q),
    .fld_i  (fld),
    .pad_i  (pad_q),
    .addr_o (fld_addr)
  );

  bd_cap_decode #(.CW(CW)) u_cap (
    .big_i (rxd_q[15]),
    .num_i (rxd_q[14:10]),
    .cap_o (cap)
  );

  bd_byte_map #(.AW(AW)) u_bmap (
    .pad_i       (pad_q),
    .byte_addr_i (byte_addr),
    .mem_addr_o  (byte_mem_addr),
    .be_o        (byte_be)
  );

  assign rd          = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_req_o   = rd | wr_q;
  assign mem_we_o    = wr_q;
  assign mem_addr_o  = wr_q ? wa_q : fld_addr;
  assign mem_be_o    = wr_q ? wbe_q : 2'b11;
  assign mem_wdata_o = wd_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign ack_o       = ack_q;
  assign ovf_err_o   = ovf_q;
  assign align_err_o = aln_q;
  assign tx_addr_o   = txa_q;
  assign tx_cnt_o    = txc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ep_q    <= '0;
      in_q    <= 1'b0;
      pad_q   <= 1'b0;
      base_q  <= '0;
      buf_q   <= '0;
      rxd_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      aln_q   <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      txa_q   <= '0;
      txc_q   <= '0;
      wr_q    <= 1'b0;
      wa_q    <= '0;
      wbe_q   <= '0;
      wd_q    <= '0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          ep_q    <= req_ep_i;
          in_q    <= req_in_i;
          pad_q   <= pad_mode_i;
          base_q  <= tbl_base_i;
          cnt_q   <= '0;
          ovf_q   <= 1'b0;
          aln_q   <= 1'b0;
          ack_q   <= 1'b0;
          state_q <= ST_RD1;
        end
        ST_RD1: state_q <= ST_RD2;
        ST_RD2: begin
          buf_q   <= AW'(mem_rdata_i);
          state_q <= ST_WT;
        end
        ST_WT: begin
          aln_q <= pad_q & buf_q[0];
          if (in_q) begin
            txa_q   <= buf_q;
            txc_q   <= mem_rdata_i[CW-1:0];
            ack_q   <= ~(pad_q & buf_q[0]);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rxd_q   <= mem_rdata_i;
            state_q <= ST_RX;
          end
        end
        ST_RX: begin
          if (rx_valid_i && !aln_q) begin
            if (cnt_q < cap) begin
              wr_q  <= 1'b1;
              wa_q  <= byte_mem_addr;
              wbe_q <= byte_be;
              wd_q  <= {rx_data_i, rx_data_i};
              cnt_q <= cnt_q + CW'(1);
            end else begin
              ovf_q <= 1'b1;
            end
          end
          if (rx_last_i) state_q <= ST_LAST;
        end
        ST_LAST: begin
          // pending data write is on the port this cycle
          if (!ovf_q && !aln_q) begin
            wr_q    <= 1'b1;
            wa_q    <= fld_addr;
            wbe_q   <= 2'b11;
            wd_q    <= {rxd_q[15:CW], cnt_q};
            state_q <= ST_WB;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WB: begin
          done_q  <= 1'b1;
          ack_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_bd_engine_chk.sv
`timescale 1ns/1ps
module usb_bd_engine_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_be_o,
  input logic          done_o,
  input logic          ack_o,
  input logic          ovf_err_o,
  input logic          align_err_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);
  // R1
  word_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[0]);
  // R5
  lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_be_o != 2'b00));
  // R6
  no_wb_after_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |-> !(mem_req_o && mem_we_o && mem_be_o == 2'b11));
  // R8
  no_write_misaligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !(mem_req_o && mem_we_o));
  // R6
  ack_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(ack_o && (ovf_err_o || align_err_o)));
endmodule

bind usb_bd_engine usb_bd_engine_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .done_o      (done_o),
  .ack_o       (ack_o),
  .ovf_err_o   (ovf_err_o),
  .align_err_o (align_err_o)
);

// File: tb/sim_usb_bd_engine.sv
`timescale 1ns/1ps
module sim_usb_bd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tbl_base = '0;
  logic        pad_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_ep = '0;
  logic        req_in = 1'b0;
  logic        req_ready;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata = '0;
  logic        done, ack, ovf_err, align_err;
  logic [15:0] tx_addr;
  logic [9:0]  tx_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usb_bd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .tbl_base_i(tbl_base), .pad_mode_i(pad_mode),
    .req_valid_i(req_valid), .req_ep_i(req_ep), .req_in_i(req_in),
    .req_ready_o(req_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .done_o(done), .ack_o(ack), .ovf_err_o(ovf_err),
    .align_err_o(align_err), .tx_addr_o(tx_addr), .tx_cnt_o(tx_cnt)
  );

  // packet memory model, indexed by 16-bit word
  logic [15:0] mem [int unsigned];

  function automatic logic [15:0] mrd(logic [15:0] a);
    int unsigned k;
    k = int'(a >> 1);
    if (mem.exists(k)) return mem[k];
    return 16'h0000;
  endfunction

  task automatic mwr(logic [15:0] a, logic [15:0] d);
    mem[int'(a >> 1)] = d;
  endtask

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        logic [15:0] cur;
        cur = mrd(mem_addr);
        if (mem_be[0]) cur[7:0]  = mem_wdata[7:0];
        if (mem_be[1]) cur[15:8] = mem_wdata[15:8];
        mwr(mem_addr, cur);
      end else begin
        mem_rdata <= mrd(mem_addr);
      end
    end
  end

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [1:0]  be;
    logic [15:0] data;
    string       tag;
  } acc_t;
  acc_t exp_q[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // every clock: each port access must match the next expected one
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected access addr", int'(mem_addr), 0);
      end else begin
        acc_t e;
        logic [15:0] m;
        e = exp_q.pop_front();
        check(mem_we == e.we, e.tag, "access kind", int'(mem_we), int'(e.we));
        check(mem_addr == e.addr, e.tag, "access addr", int'(mem_addr), int'(e.addr));
        if (e.we) begin
          check(mem_be == e.be, e.tag, "byte enables", int'(mem_be), int'(e.be));
          m = {{8{e.be[1]}}, {8{e.be[0]}}};
          check((mem_wdata & m) == (e.data & m), e.tag, "write data",
                int'(mem_wdata & m), int'(e.data & m));
        end
      end
    end
  end

  function automatic logic [15:0] fld_addr(int ep, int k, bit pad, logic [15:0] base);
    int b;
    b = int'(base) & ~7;
    if (pad) return 16'(b + ep * 16 + k * 4);
    return 16'(b + ep * 8 + k * 2);
  endfunction

  function automatic logic [15:0] map_byte(logic [15:0] a, bit pad);
    if (pad) return 16'((int'(a) >> 1) * 4);
    return a & 16'hFFFE;
  endfunction

  function automatic int cap_of(logic [15:0] w);
    int nb, c;
    nb = int'(w[14:10]);
    if (w[15]) begin
      c = 32 * (nb + 1);
      return (c > 1023) ? 1023 : c;
    end
    return 2 * nb;
  endfunction

  task automatic push(bit we, logic [15:0] a, logic [1:0] be, logic [15:0] d, string tag);
    acc_t e;
    e.we = we; e.addr = a; e.be = be; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic issue(int ep, bit in_dir, bit pad, logic [15:0] base);
    @(negedge clk);
    tbl_base  = base;
    pad_mode  = pad;
    req_ep    = 3'(ep);
    req_in    = in_dir;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9", "ready while busy", int'(req_ready), 0);
  endtask

  task automatic wait_done(string tag);
    int n;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, tag, "done seen", int'(done), 1);
  endtask

  task automatic after_done(bit e_ack, bit e_ovf, bit e_aln, string tag);
    check(ack == e_ack, tag, "ack", int'(ack), int'(e_ack));
    check(ovf_err == e_ovf, tag, "overflow flag", int'(ovf_err), int'(e_ovf));
    check(align_err == e_aln, tag, "align flag", int'(align_err), int'(e_aln));
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", int'(done), 0);
    check(ack == e_ack, "R9", "ack held", int'(ack), int'(e_ack));
    check(req_ready == 1'b1, "R9", "ready after done", int'(req_ready), 1);
    check(exp_q.size() == 0, tag, "accesses left", exp_q.size(), 0);
  endtask

  task automatic do_in(int ep, bit pad, logic [15:0] base, string tag);
    logic [15:0] a, c;
    bit aln;
    a = mrd(fld_addr(ep, 0, pad, base));
    c = mrd(fld_addr(ep, 1, pad, base));
    aln = pad && a[0];
    push(1'b0, fld_addr(ep, 0, pad, base), 2'b11, 16'h0, tag);
    push(1'b0, fld_addr(ep, 1, pad, base), 2'b11, 16'h0, tag);
    issue(ep, 1'b1, pad, base);
    wait_done(tag);
    check(tx_addr == a, tag, "tx address", int'(tx_addr), int'(a));
    check(tx_cnt == c[9:0], tag, "tx count", int'(tx_cnt), int'(c[9:0]));
    after_done(!aln, 1'b0, aln, tag);
  endtask

  task automatic do_out(int ep, bit pad, logic [15:0] base, int nbytes, int gap,
                        int seed, string tag);
    logic [15:0] a, w, wa;
    bit aln;
    int cap, nw;
    a   = mrd(fld_addr(ep, 2, pad, base));
    wa  = fld_addr(ep, 3, pad, base);
    w   = mrd(wa);
    aln = pad && a[0];
    cap = cap_of(w);
    nw  = (nbytes < cap) ? nbytes : cap;
    push(1'b0, fld_addr(ep, 2, pad, base), 2'b11, 16'h0, tag);
    push(1'b0, wa, 2'b11, 16'h0, tag);
    if (!aln) begin
      for (int i = 0; i < nw; i++) begin
        logic [15:0] ba;
        logic [7:0] b;
        ba = a + 16'(i);
        b  = 8'(seed + i * 7);
        push(1'b1, map_byte(ba, pad), ba[0] ? 2'b10 : 2'b01, {b, b}, tag);
      end
      if (nbytes <= cap) push(1'b1, wa, 2'b11, {w[15:10], 10'(nbytes)}, "R7");
    end
    issue(ep, 1'b0, pad, base);
    repeat (3) @(negedge clk);
    if (nbytes == 0) begin
      rx_last = 1'b1;
      @(negedge clk);
      rx_last = 1'b0;
    end else begin
      for (int i = 0; i < nbytes; i++) begin
        rx_valid = 1'b1;
        rx_data  = 8'(seed + i * 7);
        rx_last  = (i == nbytes - 1);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    wait_done(tag);
    after_done(!aln && nbytes <= cap, !aln && nbytes > cap, aln, tag);
    if (aln || nbytes > cap)
      check(mrd(wa) == w, "R6", "descriptor untouched", int'(mrd(wa)), int'(w));
    else
      check(mrd(wa) == {w[15:10], 10'(nbytes)}, "R7", "count stored",
            int'(mrd(wa)), int'({w[15:10], 10'(nbytes)}));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "reset ready", int'(req_ready), 1);
    check(done == 1'b0, "R9", "reset done", int'(done), 0);
    check(mem_req == 1'b0, "R9", "reset access", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3: normal scheme IN, base low bits ignored, count high bits ignored
    mwr(16'h0110, 16'h0240);
    mwr(16'h0112, 16'hFC55);
    do_in(2, 1'b0, 16'h0105, "R3");

    // R2: padded scheme IN
    mwr(16'h0250, 16'h0300);
    mwr(16'h0254, 16'h0040);
    do_in(5, 1'b1, 16'h0200, "R2");

    // R8: padded scheme odd transmit address
    mwr(16'h0210, 16'h0301);
    mwr(16'h0214, 16'h0008);
    do_in(1, 1'b1, 16'h0200, "R8");

    // R5: normal OUT to odd buffer, flag 0 count 4 -> capacity 8
    mwr(16'h010C, 16'h0401);
    mwr(16'h010E, {1'b0, 5'd4, 10'h3FF});
    do_out(1, 1'b0, 16'h0100, 5, 0, 8'h11, "R5");

    // R6: overflow, 10 bytes into 8
    mwr(16'h010E, {1'b0, 5'd4, 10'h000});
    do_out(1, 1'b0, 16'h0100, 10, 1, 8'h23, "R6");

    // R4: flag 1 count 0 -> 32 bytes, exact fit then one over
    mwr(16'h011C, 16'h0600);
    mwr(16'h011E, {1'b1, 5'd0, 10'h000});
    do_out(3, 1'b0, 16'h0100, 32, 0, 8'h40, "R4");
    do_out(3, 1'b0, 16'h0100, 33, 0, 8'h41, "R4");

    // R4: flag 0 count 0 -> capacity 0; R7: zero-length packet
    mwr(16'h0124, 16'h0700);
    mwr(16'h0126, {1'b0, 5'd0, 10'h155});
    do_out(4, 1'b0, 16'h0100, 1, 0, 8'h50, "R4");
    do_out(4, 1'b0, 16'h0100, 0, 0, 8'h51, "R7");

    // R4: flag 1 count 31 -> capped 1023
    mwr(16'h0134, 16'h0800);
    mwr(16'h0136, {1'b1, 5'd31, 10'h000});
    do_out(6, 1'b0, 16'h0100, 1023, 0, 8'h60, "R4");
    do_out(6, 1'b0, 16'h0100, 1024, 0, 8'h61, "R4");

    // R2: padded OUT, flag 0 count 3 -> capacity 6, spaced bytes
    mwr(16'h0228, 16'h0500);
    mwr(16'h022C, {1'b0, 5'd3, 10'h000});
    do_out(2, 1'b1, 16'h0200, 6, 2, 8'h70, "R2");

    // R8: padded OUT with odd buffer
    mwr(16'h0228, 16'h0501);
    do_out(2, 1'b1, 16'h0200, 3, 0, 8'h80, "R8");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule